// File: doc/BRIEF.md
# Reference-Edge Clock Ratio Meter

This block measures how fast an internal oscillator runs by comparing it with a slower, more precise reference. The whole block is clocked by the oscillator under test. It counts that clock's cycles between qualified rising edges of a chosen reference and returns the total, so that calibration software can work out the frequency ratio and trim the oscillator.

Three references are available. One is a low-speed crystal input. Another is a high-speed clock divided by 32, which is produced inside the block for use when no crystal is present. The third is a periodic event pulse, such as a wakeup tick. Each reference is resynchronised into the measured domain through two flip-flops and a rising-edge detector.

A capture can span 1, 2, 4 or 8 reference periods. Several back-to-back captures can be summed into one result, which helps when the measured clock is slow and a single period holds only a few counts. The first qualifying edge after start only arms the counter, so a partial period is never counted. The 32-bit sum saturates instead of wrapping, and a flag records that it saturated.

Top module: `refclk_ratio_meter`

## Requirements
- R1: After a start, the first rising edge of the selected reference only arms the counter. The result counts measured-clock cycles from that edge up to the final capture edge, so it equals the number of cycles that elapse across the reference periods that are measured.
- R2: `psc_i` sets the number of reference periods in one capture: code 0 gives 1 period, code 1 gives 2, code 2 gives 4 and code 3 gives 8.
- R3: `ncap_i` sets how many back-to-back captures are summed into one result, and a value of 0 counts as 1. The result equals ncap × periods-per-capture × reference period, in measured-clock cycles.
- R4: `ref_sel_i` chooses the reference: code 0 is the crystal input `xtal_ref_i`, code 1 is the internal divided high-speed clock, and codes 2 and 3 are the event pulse input `evt_i`.
- R5: The divided high-speed reference has a period of exactly 32 `hs_clk_i` cycles.
- R6: The result is RES_W bits wide (default 32) and saturates at all ones instead of wrapping. When any increment would have gone past all ones, `ovf_o` is set together with the result.
- R7: `done_o` is high for exactly one cycle when the programmed number of captures has completed, and the result and overflow are loaded in that same cycle. Both then hold until the next start, and a start clears them to 0.
- R8: If `ref_sel_i` or `psc_i` differs from the value latched at start while a measurement is in progress, the block aborts. `busy_o` falls in the next cycle, `done_o` is not asserted, and the result stays 0. A start in the same cycle takes priority and begins a new measurement with the new values.
- R9: While reset is active and after it is released, `busy_o`, `done_o`, `result_o` and `ovf_o` are all 0.
- R10: `busy_o` is high from the cycle after `start_i` until the cycle in which `done_o` is asserted or an abort takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Measured oscillator clock; clocks all control logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_clk_i | input | 1 | High-speed clock that feeds the internal divide-by-32 reference |
| xtal_ref_i | input | 1 | Asynchronous low-speed crystal reference |
| evt_i | input | 1 | Asynchronous periodic event pulse reference |
| ref_sel_i | input | 2 | Reference select (0 crystal, 1 divided clock, 2/3 event) |
| psc_i | input | 2 | Capture prescaler code (1, 2, 4 or 8 periods) |
| ncap_i | input | NCAP_W | Number of captures to sum (0 treated as 1) |
| start_i | input | 1 | One-cycle pulse that starts or restarts a measurement |
| busy_o | output | 1 | Measurement in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | RES_W | Accumulated cycle count, saturating |
| ovf_o | output | 1 | Set when the result saturated |

## Verification
The hardest condition to reach from the ports is saturation, because the default width would need billions of cycles. The bench builds the block with a 10-bit result and then uses a slow crystal period with the widest prescaler, so the true sum exceeds the range. The abort path is also hard to reach: it needs a configuration change after arming and before completion. The bench produces this by waiting a fixed number of cycles into a long multi-capture run before changing the prescaler or the select, and then it watches for the missing done pulse over a window longer than the run would have taken.

// File: rtl/rcm_pkg.sv
package rcm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } rcm_state_e;

    localparam int NSRC = 3;

    // Last prescaler edge index for a capture: periods per capture minus one.
    function automatic logic [2:0] psc_last(input logic [1:0] code);
        logic [2:0] r;
        case (code)
            2'd0:    r = 3'd0;
            2'd1:    r = 3'd1;
            2'd2:    r = 3'd3;
            default: r = 3'd7;
        endcase
        return r;
    endfunction

    // Maps the select code to the source bit index (0 crystal, 1 divided, 2 event).
    function automatic logic [1:0] src_index(input logic [1:0] sel);
        logic [1:0] r;
        case (sel)
            2'd0:    r = 2'd0;
            2'd1:    r = 2'd1;
            default: r = 2'd2;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rcm_sync.sv
module rcm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] ff_d, ff_q;

    always_comb begin
        ff_d = {ff_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '0;
        else        ff_q <= ff_d;
    end

    assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/rcm_hs_div.sv
module rcm_hs_div #(
    parameter int DIV = 32
) (
    input  logic hs_clk_i,
    input  logic rst_n,
    output logic div_o
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tog;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (div_q.cnt == CNT_LAST) begin
            div_d.cnt = '0;
            div_d.tog = ~div_q.tog;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge hs_clk_i or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign div_o = div_q.tog;
endmodule

// File: rtl/rcm_ref_front.sv
module rcm_ref_front
    import rcm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic [1:0]      sel_i,
    output logic            edge_o
);
    logic [NSRC-1:0] synced;
    logic            cur;
    logic            prev_d, prev_q;

    for (genvar g = 0; g < NSRC; g++) begin : g_sync
        rcm_sync #(.STAGES(2)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (src_i[g]),
            .q_o   (synced[g])
        );
    end

    always_comb begin
        cur    = synced[src_index(sel_i)];
        prev_d = cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign edge_o = cur & ~prev_q;
endmodule

// File: rtl/refclk_ratio_meter.sv
module refclk_ratio_meter
    import rcm_pkg::*;
#(
    parameter int RES_W  = 32,
    parameter int NCAP_W = 8,
    parameter int HS_DIV = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs_clk_i,
    input  logic              xtal_ref_i,
    input  logic              evt_i,
    input  logic [1:0]        ref_sel_i,
    input  logic [1:0]        psc_i,
    input  logic [NCAP_W-1:0] ncap_i,
    input  logic              start_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [RES_W-1:0]  result_o,
    output logic              ovf_o
);
    localparam logic [RES_W-1:0] ACC_MAX = '1;

    typedef struct packed {
        rcm_state_e        state;
        logic [1:0]        sel;
        logic [1:0]        psc;
        logic [NCAP_W-1:0] ncap_last;
        logic [2:0]        psc_cnt;
        logic [NCAP_W-1:0] cap_cnt;
        logic [RES_W-1:0]  acc;
        logic              acc_ovf;
        logic [RES_W-1:0]  result;
        logic              ovf;
        logic              done;
    } core_t;

    core_t core_d, core_q;

    logic              hs_ref;
    logic              ref_edge;
    logic [RES_W-1:0]  acc_inc;
    logic              ovf_inc;
    logic              cfg_changed;

    rcm_hs_div #(.DIV(HS_DIV)) u_hs_div (
        .hs_clk_i (hs_clk_i),
        .rst_n    (rst_n),
        .div_o    (hs_ref)
    );

    rcm_ref_front u_front (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  ({evt_i, hs_ref, xtal_ref_i}),
        .sel_i  (ref_sel_i),
        .edge_o (ref_edge)
    );

    always_comb begin
        core_d      = core_q;
        core_d.done = 1'b0;

        acc_inc     = (core_q.acc == ACC_MAX) ? core_q.acc : core_q.acc + 1'b1;
        ovf_inc     = core_q.acc_ovf | (core_q.acc == ACC_MAX);
        cfg_changed = (ref_sel_i != core_q.sel) || (psc_i != core_q.psc);

        if (start_i) begin
            core_d.state     = ST_ARM;
            core_d.sel       = ref_sel_i;
            core_d.psc       = psc_i;
            core_d.ncap_last = (ncap_i == '0) ? '0 : ncap_i - 1'b1;
            core_d.psc_cnt   = '0;
            core_d.cap_cnt   = '0;
            core_d.acc       = '0;
            core_d.acc_ovf   = 1'b0;
            core_d.result    = '0;
            core_d.ovf       = 1'b0;
        end else if (core_q.state != ST_IDLE && cfg_changed) begin
            core_d.state = ST_IDLE;
        end else begin
            case (core_q.state)
                ST_ARM: begin
                    if (ref_edge) core_d.state = ST_RUN;
                end
                ST_RUN: begin
                    core_d.acc     = acc_inc;
                    core_d.acc_ovf = ovf_inc;
                    if (ref_edge) begin
                        if (core_q.psc_cnt == psc_last(core_q.psc)) begin
                            core_d.psc_cnt = '0;
                            if (core_q.cap_cnt == core_q.ncap_last) begin
                                core_d.state  = ST_IDLE;
                                core_d.done   = 1'b1;
                                core_d.result = acc_inc;
                                core_d.ovf    = ovf_inc;
                            end else begin
                                core_d.cap_cnt = core_q.cap_cnt + 1'b1;
                            end
                        end else begin
                            core_d.psc_cnt = core_q.psc_cnt + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign busy_o   = (core_q.state != ST_IDLE);
    assign done_o   = core_q.done;
    assign result_o = core_q.result;
    assign ovf_o    = core_q.ovf;
endmodule

// File: rtl/rcm_checker.sv
module rcm_checker #(
    parameter int RES_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [1:0]       ref_sel_i,
    input logic [1:0]       psc_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [RES_W-1:0] result_o,
    input logic             ovf_o
);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(busy_o) && !busy_o));

    // R6
    sat_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (result_o == {RES_W{1'b1}}));

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_o && !$past(start_i)) |-> $stable(result_o));

    // R10
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (busy_o && result_o == '0 && !ovf_o));

    // R8
    cfg_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !start_i && (psc_i != $past(psc_i) || ref_sel_i != $past(ref_sel_i)))
        |=> (!busy_o && !done_o));
endmodule

bind refclk_ratio_meter rcm_checker #(.RES_W(RES_W)) u_rcm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .ref_sel_i (ref_sel_i),
    .psc_i     (psc_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .result_o  (result_o),
    .ovf_o     (ovf_o)
);

// File: tb/tb_refclk_ratio_meter.sv
module tb_refclk_ratio_meter;
    localparam int RES_W  = 10;
    localparam int NCAP_W = 3;
    localparam int MAXR   = (1 << RES_W) - 1;

    // Time unit read as 1 ns: 8 ns period = 125 MHz measured clock.
    logic clk = 1'b0, hs_clk = 1'b0, rst_n = 1'b0;
    logic xt = 1'b0, ev = 1'b0, start = 1'b0;
    logic [1:0] sel = 2'd0, psc = 2'd0;
    logic [NCAP_W-1:0] ncap = 3'd1;
    logic busy, done, ovf;
    logic [RES_W-1:0] result;

    int xt_per = 6;
    int ev_per = 9;
    int vecs = 0, fails = 0;

    refclk_ratio_meter #(.RES_W(RES_W), .NCAP_W(NCAP_W), .HS_DIV(32)) dut (
        .clk(clk), .rst_n(rst_n), .hs_clk_i(hs_clk), .xtal_ref_i(xt), .evt_i(ev),
        .ref_sel_i(sel), .psc_i(psc), .ncap_i(ncap), .start_i(start),
        .busy_o(busy), .done_o(done), .result_o(result), .ovf_o(ovf)
    );

    always #4 clk = ~clk;
    // 10-unit high-speed clock, rising at odd times so it never meets a clk edge:
    // divided period 320 = 40 measured cycles.
    initial begin
        #1 hs_clk = 1'b1;
        forever #5 hs_clk = ~hs_clk;
    end

    initial begin
        forever begin
            repeat (xt_per / 2) @(negedge clk);
            xt = 1'b1;
            repeat (xt_per - xt_per / 2) @(negedge clk);
            xt = 1'b0;
        end
    end

    initial begin
        forever begin
            repeat (ev_per - 1) @(negedge clk);
            ev = 1'b1;
            @(negedge clk);
            ev = 1'b0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp, input string what);
        vecs++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic run(input int s, input int p, input int n, input int per, input string tag);
        int exp_full;
        int exp_r;
        int exp_o;
        bit seen;
        exp_full = ((n == 0) ? 1 : n) * (1 << p) * per;
        exp_o    = (exp_full > MAXR) ? 1 : 0;
        exp_r    = (exp_o == 1) ? MAXR : exp_full;
        @(negedge clk);
        sel  = s[1:0];
        psc  = p[1:0];
        ncap = n[NCAP_W-1:0];
        repeat (6) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10", int'(busy), 1, "busy after start");
        chk("R7", int'(result), 0, "result cleared by start");
        chk("R7", int'(ovf), 0, "ovf cleared by start");
        seen = 1'b0;
        for (int i = 0; i < 6000 && !seen; i++) begin
            @(negedge clk);
            if (done) seen = 1'b1;
        end
        chk(tag, int'(seen), 1, "done observed");
        chk(tag, int'(result), exp_r, "result");
        chk("R6", int'(ovf), exp_o, "overflow flag");
        chk("R10", int'(busy), 0, "busy low at done");
        @(negedge clk);
        chk("R7", int'(done), 0, "done one cycle");
        chk("R7", int'(result), exp_r, "result holds");
    endtask

    task automatic abort_run(input int change_sel, input string tag);
        int dones;
        @(negedge clk);
        sel  = 2'd0;
        psc  = 2'd3;
        ncap = 3'd3;
        repeat (6) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        if (change_sel != 0) sel = 2'd2;
        else                 psc = 2'd2;
        @(negedge clk);
        chk(tag, int'(busy), 0, "busy dropped on config change");
        dones = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (done) dones++;
        end
        chk(tag, dones, 0, "no done after abort");
        chk(tag, int'(result), 0, "result stays cleared after abort");
    endtask

    function automatic string pick_tag(input int s, input int p, input int n);
        if (s == 1)      return "R5";
        else if (s == 2) return "R4";
        else if (n > 1)  return "R3";
        else if (p > 0)  return "R2";
        else             return "R1";
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R9: state during reset
        chk("R9", int'(busy), 0, "busy in reset");
        chk("R9", int'(done), 0, "done in reset");
        chk("R9", int'(result), 0, "result in reset");
        chk("R9", int'(ovf), 0, "ovf in reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9", int'(busy), 0, "busy after reset");
        chk("R9", int'(result), 0, "result after reset");

        // R1 R2 R3 R4 R5: sweep sources, prescaler codes and capture counts
        for (int s = 0; s < 3; s++) begin
            for (int p = 0; p < 4; p++) begin
                for (int n = 1; n < 4; n++) begin
                    run(s, p, n, (s == 0) ? xt_per : ((s == 1) ? 40 : ev_per), pick_tag(s, p, n));
                end
            end
        end
        run(3, 1, 2, ev_per, "R4");     // code 3 also selects the event pulse
        run(0, 2, 0, xt_per, "R3");     // zero capture count acts as one
        run(1, 3, 7, 40, "R3");         // largest capture count

        // R8: aborts on prescaler change and on select change
        abort_run(0, "R8");
        abort_run(1, "R8");

        // R6: saturation with a slow crystal, then an in-range run that clears it
        xt_per = 200;
        repeat (450) @(negedge clk);
        run(0, 3, 1, 200, "R6");
        run(0, 2, 1, 200, "R6");

        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule